// File: doc/BRIEF.md
# Key-Guarded Byte Store Controller

This block sits on a small CPU-side register bus and fronts a byte-wide data store held in on-chip registers. Software reads a byte by loading an address and pulsing a read bit; the byte lands in a data register one clock later. Writes take many cycles and are guarded: software must write the two-key pattern 55h then AAh to a key register and then, as the very next bus access, set the write bit. The write bit only takes effect if the write-enable bit was already set before that access.

Once started, a write runs for a parameterized number of cycles. During that time the busy bit reads back as 1, and any further read or write request is ignored. When the write finishes, hardware clears busy, commits the byte and sets a sticky completion flag. That flag, gated by an interrupt-enable bit, drives the interrupt line. A memory-select bit set to 1 points at a store this block does not serve, so requests made with it set do nothing.

Register map (bus_addr): 0 = address, 1 = data, 2 = control, 3 = key (write-only, reads 0). Control bits: 0 read request (reads 0), 1 write/busy, 2 write-enable, 3 completion flag, 4 interrupt enable, 7 memory select. Bits 5 and 6 read 0.

Top module: `ee_unlock_ctrl`

## Requirements
- R1: A bus write to control (offset 2) with bit 0 set and bit 7 clear, while not busy, loads the data register (offset 1) with the stored byte at the current address; the value reads back right after that clock edge.
- R2: The data register holds its value until a read request completes or the bus writes offset 1, which loads the written byte.
- R3: A write starts only after a key write of 55h, then a key write of AAh, then a control write with bit 1 set, with no other bus access in between; a wrong key, a wrong order or any interleaved access (read or write) starts nothing.
- R4: The write bit takes effect only if write-enable (control bit 2) was already 1 before the control write that sets bit 1.
- R5: Write-enable changes only on a bus write to control; hardware never clears it, including when a write finishes.
- R6: A started write keeps busy (control bit 1) at 1 for exactly WR_CYCLES clock edges, then clears busy, commits the latched byte and sets the completion flag (control bit 3), which stays 1 until a control write carries bit 3 = 0.
- R7: Clearing write-enable while busy does not stop or change the write in progress.
- R8: While busy, read requests leave the data register unchanged and a fresh key sequence starts no second write; the running write uses the address and data latched at its start.
- R9: A read or write request whose control write carries bit 7 = 1 has no effect.
- R10: Addresses wrap to the low log2(DEPTH) bits; the address register itself reads back all 8 bits as written.
- R11: irq_o equals the completion flag ANDed with control bit 4.
- R12: After reset, all four registers read 0, irq_o is 0 and every stored byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at bus_addr (combinational) |
| irq_o | output | 1 | Completion interrupt |

## Verification
Register read-back is combinational, so a register write is visible just after the edge that samples it, and a read request shows its byte in the data register after that same edge. Busy rises on the edge that takes the final control write and falls WR_CYCLES edges later. The bench checks busy still set after WR_CYCLES-1 further edges and cleared after one more. All sampling happens 1 ns after a falling edge through a side-effect-free peek, which does not raise bus_sel, so observing the registers never disturbs the key sequence.

// File: rtl/ee_unlock_pkg.sv
package ee_unlock_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] REG_ADR = 2'd0;
  localparam logic [1:0] REG_DAT = 2'd1;
  localparam logic [1:0] REG_CTL = 2'd2;
  localparam logic [1:0] REG_KEY = 2'd3;

  localparam int CTL_RD   = 0;
  localparam int CTL_WR   = 1;
  localparam int CTL_WEN  = 2;
  localparam int CTL_DONE = 3;
  localparam int CTL_IEN  = 4;
  localparam int CTL_MSEL = 7;

  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_FIRST = 2'd1,
    UL_ARMED = 2'd2
  } unlock_t;

  // Next key-tracker state for one bus access.
  function automatic unlock_t unlock_next(unlock_t cur, logic key_wr,
                                          logic [BYTE_W-1:0] val);
    case (cur)
      UL_IDLE:  return (key_wr && val == KEY_FIRST)  ? UL_FIRST : UL_IDLE;
      UL_FIRST: return (key_wr && val == KEY_SECOND) ? UL_ARMED : UL_IDLE;
      default:  return UL_IDLE;
    endcase
  endfunction

  // Read-back image of the control register.
  function automatic logic [BYTE_W-1:0] ctl_image(logic busy, logic wen,
                                                  logic done, logic ien,
                                                  logic msel);
    logic [BYTE_W-1:0] v;
    v = '0;
    v[CTL_WR]   = busy;
    v[CTL_WEN]  = wen;
    v[CTL_DONE] = done;
    v[CTL_IEN]  = ien;
    v[CTL_MSEL] = msel;
    return v;
  endfunction
endpackage

// File: rtl/ee_unlock_seq.sv
module ee_unlock_seq
  import ee_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access_i,
  input  logic              key_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              armed_o
);
  unlock_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UL_IDLE;
    end else if (access_i) begin
      state_q <= unlock_next(state_q, key_wr_i, wdata_i);
    end
  end

  assign armed_o = (state_q == UL_ARMED);

  // R3: the armed state is only reachable straight from the first-key state
  p_armed_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UL_ARMED) |-> ($past(state_q) == UL_FIRST));

  // R3: an access while armed always drops the tracker back to idle
  p_armed_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && access_i) |=> (state_q == UL_IDLE));
endmodule

// File: rtl/ee_write_timer.sv
module ee_write_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic finish_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign finish_o = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (finish_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R6: the countdown never exceeds the programmed duration
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(CYCLES)));

  // R6: completion always releases busy on the next edge
  p_finish_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> !busy_o);
endmodule

// File: rtl/ee_byte_store.sv
module ee_byte_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [DW-1:0]            rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R6: a commit lands the byte at its address
  p_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (raddr_i == waddr_i)) |=>
      (rdata_o == $past(wdata_i)) || (raddr_i != $past(raddr_i)));
endmodule

// File: rtl/ee_unlock_ctrl.sv
module ee_unlock_ctrl
  import ee_unlock_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int AW = $clog2(DEPTH);

  logic [BYTE_W-1:0] adr_q, dat_q, wd_q, mem_rdata;
  logic [AW-1:0]     wa_q;
  logic              wen_q, ien_q, msel_q, done_q;

  // Named bus events
  logic wr_acc, adr_wr, dat_wr, ctl_wr, key_wr;
  assign wr_acc = bus_sel && bus_we;
  assign adr_wr = wr_acc && (bus_addr == REG_ADR);
  assign dat_wr = wr_acc && (bus_addr == REG_DAT);
  assign ctl_wr = wr_acc && (bus_addr == REG_CTL);
  assign key_wr = wr_acc && (bus_addr == REG_KEY);

  logic armed, busy, finish, start_evt, read_evt;

  ee_unlock_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .access_i (bus_sel),
    .key_wr_i (key_wr),
    .wdata_i  (bus_wdata),
    .armed_o  (armed)
  );

  assign start_evt = armed && ctl_wr && bus_wdata[CTL_WR] && wen_q &&
                     !bus_wdata[CTL_MSEL] && !busy;
  assign read_evt  = ctl_wr && bus_wdata[CTL_RD] && !bus_wdata[CTL_MSEL] &&
                     !busy;

  ee_write_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_evt),
    .busy_o   (busy),
    .finish_o (finish)
  );

  ee_byte_store #(.DEPTH(DEPTH), .DW(BYTE_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (finish),
    .waddr_i (wa_q),
    .wdata_i (wd_q),
    .raddr_i (adr_q[AW-1:0]),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q  <= '0;
      dat_q  <= '0;
      wd_q   <= '0;
      wa_q   <= '0;
      wen_q  <= 1'b0;
      ien_q  <= 1'b0;
      msel_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (adr_wr) adr_q <= bus_wdata;
      if (read_evt)    dat_q <= mem_rdata;
      else if (dat_wr) dat_q <= bus_wdata;
      if (start_evt) begin
        wa_q <= adr_q[AW-1:0];
        wd_q <= dat_q;
      end
      if (ctl_wr) begin
        wen_q  <= bus_wdata[CTL_WEN];
        ien_q  <= bus_wdata[CTL_IEN];
        msel_q <= bus_wdata[CTL_MSEL];
      end
      if (finish)      done_q <= 1'b1;
      else if (ctl_wr) done_q <= done_q & bus_wdata[CTL_DONE];
    end
  end

  always_comb begin
    case (bus_addr)
      REG_ADR: bus_rdata = adr_q;
      REG_DAT: bus_rdata = dat_q;
      REG_CTL: bus_rdata = ctl_image(busy, wen_q, done_q, ien_q, msel_q);
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = done_q && ien_q;

  // R3: busy only ever rises out of an armed tracker and a control write
  p_start_keyed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(armed) && $past(ctl_wr)));

  // R4: write-enable was already set in the cycle of the starting access
  p_start_needs_wen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen_q));

  // R5: only a control write moves write-enable
  p_wen_hw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(wen_q));

  // R6: completion flag is up when busy drops, and sticks until cleared
  p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctl_wr) |=> done_q);

  // R2: the data register is stable without a read or a data write
  p_dat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_evt && !dat_wr) |=> $stable(dat_q));

  // R8: control writes during busy never disturb the data register
  p_busy_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr) |=> $stable(dat_q));

  // R9: a request carrying memory-select never starts a write
  p_msel_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[CTL_MSEL] && !busy) |=> !busy);
endmodule

// File: tb/sim_ee_unlock_ctrl.sv
`timescale 1ns/1ps
module sim_ee_unlock_ctrl;
  localparam int DEPTH = 64;
  localparam int WRC   = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_o;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];

  always #5 clk = ~clk;

  ee_unlock_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // Bench-side restatement of the control read-back layout
  function automatic logic [7:0] exp_ctl(bit busy, bit wen, bit done, bit ien, bit msel);
    return {msel, 2'b00, ien, done, wen, busy, 1'b0};
  endfunction
  function automatic int wrap(logic [7:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    bus_sel = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock_go(input logic [7:0] ctl);
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd2, ctl);
  endtask

  task automatic read_mem(input logic [7:0] a, output logic [7:0] v);
    wr(2'd0, a); wr(2'd2, 8'h01); peek(2'd1, v);
  endtask

  task automatic stage(input logic [7:0] a, input logic [7:0] d, input logic [7:0] ctl);
    wr(2'd0, a); wr(2'd1, d); wr(2'd2, ctl);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R12: reset state
    peek(2'd0, v); chk("R12 adr", v, 8'h00);
    peek(2'd1, v); chk("R12 dat", v, 8'h00);
    peek(2'd2, v); chk("R12 ctl", v, 8'h00);
    peek(2'd3, v); chk("R12 key", v, 8'h00);
    chk("R12 irq", {7'd0, irq_o}, 8'h00);
    read_mem(8'h3F, v); chk("R12 store", v, 8'h00);

    // R6: timed write with exact busy window
    stage(8'h05, 8'h3C, 8'h04);
    unlock_go(8'h06);
    peek(2'd2, v); chk("R6 busy at start", v, exp_ctl(1, 1, 0, 0, 0));
    idle(WRC - 1);
    peek(2'd2, v); chk("R6 busy before end", v, exp_ctl(1, 1, 0, 0, 0));
    idle(1);
    peek(2'd2, v); chk("R6 done, R5 wen kept", v, exp_ctl(0, 1, 1, 0, 0));
    idle(5);
    peek(2'd2, v); chk("R6 done sticky", v, exp_ctl(0, 1, 1, 0, 0));
    model[5] = 8'h3C;

    // R1: read returns stored byte one edge after the request
    read_mem(8'h05, v); chk("R1 read", v, 8'h3C);
    // R2: data register holds, and takes a bus write
    idle(4); rd(2'd0, v);
    peek(2'd1, v); chk("R2 hold", v, 8'h3C);
    wr(2'd1, 8'h77); rd(2'd2, v);
    peek(2'd1, v); chk("R2 bus write", v, 8'h77);

    // R10: address wraps, register keeps all bits
    stage(8'h45, 8'h99, 8'h04);
    unlock_go(8'h06);
    peek(2'd0, v); chk("R10 adr full", v, 8'h45);
    idle(WRC + 1);
    model[5] = 8'h99;
    read_mem(8'h05, v); chk("R10 wrap", v, 8'h99);

    // R7: dropping write-enable mid-write
    stage(8'h10, 8'hA1, 8'h04);
    unlock_go(8'h06);
    wr(2'd2, 8'h00);
    peek(2'd2, v); chk("R7 still busy", v, exp_ctl(1, 0, 0, 0, 0));
    idle(WRC + 1);
    peek(2'd2, v); chk("R7 completes", v, exp_ctl(0, 0, 1, 0, 0));
    model[8'h10] = 8'hA1;
    read_mem(8'h10, v); chk("R7 byte", v, 8'hA1);

    // R4: write bit without prior write-enable
    stage(8'h11, 8'h5A, 8'h00);
    unlock_go(8'h06);
    peek(2'd2, v); chk("R4 no start", v & 8'h02, 8'h00);
    idle(WRC + 1);
    peek(2'd2, v); chk("R5 wen not cleared by hw", v & 8'h04, 8'h04);
    read_mem(8'h11, v); chk("R4 byte", v, 8'h00);

    // R3: four broken sequences
    for (int k = 0; k < 4; k++) begin
      stage(8'h20 + 8'(k), 8'hC0 + 8'(k), 8'h04);
      case (k)
        0: begin wr(2'd3, 8'h55); rd(2'd0, v); wr(2'd3, 8'hAA); wr(2'd2, 8'h06); end
        1: begin wr(2'd3, 8'h55); wr(2'd3, 8'hA5); wr(2'd2, 8'h06); end
        2: begin wr(2'd3, 8'h55); wr(2'd3, 8'hAA); wr(2'd1, 8'hC0 + 8'(k)); wr(2'd2, 8'h06); end
        default: begin wr(2'd3, 8'hAA); wr(2'd3, 8'h55); wr(2'd2, 8'h06); end
      endcase
      peek(2'd2, v); chk("R3 broken key", v & 8'h02, 8'h00);
      idle(WRC + 1);
      read_mem(8'h20 + 8'(k), v); chk("R3 byte untouched", v, 8'h00);
    end

    // R8: requests during busy
    stage(8'h30, 8'h33, 8'h04);
    unlock_go(8'h06);
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h05);
    peek(2'd1, v); chk("R8 read ignored", v, 8'h33);
    unlock_go(8'h06);
    idle(WRC + 1);
    peek(2'd2, v); chk("R8 idle after", v & 8'h02, 8'h00);
    model[8'h30] = 8'h33;
    read_mem(8'h30, v); chk("R8 latched addr", v, 8'h33);
    read_mem(8'h05, v); chk("R8 no second write", v, 8'h99);

    // R9: memory-select set
    stage(8'h31, 8'h44, 8'h84);
    unlock_go(8'h86);
    peek(2'd2, v); chk("R9 write ignored", v, exp_ctl(0, 1, 0, 0, 1));
    wr(2'd1, 8'h12); wr(2'd2, 8'h81);
    peek(2'd1, v); chk("R9 read ignored", v, 8'h12);
    idle(WRC + 1);
    read_mem(8'h31, v); chk("R9 byte", v, 8'h00);

    // R11: interrupt gating
    stage(8'h32, 8'h5E, 8'h14);
    unlock_go(8'h16);
    chk("R11 irq during busy", {7'd0, irq_o}, 8'h00);
    idle(WRC + 1);
    model[8'h32] = 8'h5E;
    #1 chk("R11 irq on", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h0C); #1 chk("R11 ien off", {7'd0, irq_o}, 8'h00);
    wr(2'd2, 8'h1C); #1 chk("R11 ien on", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h14); #1 chk("R11 done cleared", {7'd0, irq_o}, 8'h00);
    peek(2'd2, v); chk("R6 flag clear", v, exp_ctl(0, 1, 0, 1, 0));

    // Random trials: 0 valid, 1 no enable (R4), 2 interleaved access (R3), 3 msel (R9)
    for (int t = 0; t < 40; t++) begin
      int mode;
      logic [7:0] a, d;
      mode = int'($urandom % 4);
      a = 8'($urandom);
      d = 8'($urandom);
      case (mode)
        0: begin stage(a, d, 8'h04); unlock_go(8'h06); end
        1: begin stage(a, d, 8'h00); unlock_go(8'h06); end
        2: begin stage(a, d, 8'h04); wr(2'd3, 8'h55); rd(2'd3, v); wr(2'd3, 8'hAA); wr(2'd2, 8'h06); end
        default: begin stage(a, d, 8'h84); unlock_go(8'h86); end
      endcase
      peek(2'd2, v);
      chk("R3 random start state", v & 8'h02, (mode == 0) ? 8'h02 : 8'h00);
      idle(WRC + 2);
      if (mode == 0) model[wrap(a)] = d;
    end
    for (int t = 0; t < 30; t++) begin
      logic [7:0] a;
      a = 8'($urandom);
      read_mem(a, v);
      chk("R1 R10 random readback", v, model[wrap(a)]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule